// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port With Peripheral Takeover

This block gives a processor three memory-mapped registers that control a bank of general-purpose pins: a direction register, an output data latch and a pin-level register. Software writes the latch and the direction bits through a simple register bus. Reads of the latch return what software stored. Reads of the pin register return the pad levels after they pass through a two-flop synchronizer. A write to either the pin address or the latch address lands in the same output latch.

Any bit can be handed to an on-chip peripheral through a per-bit select. While selected, the peripheral supplies the driven value and its own output enable. A separate per-bit force-input line keeps a pin's driver off no matter what the other controls say. None of these overrides alters the stored direction register, so software reads back exactly what it wrote. The synchronized pin level is always offered to the peripherals, whatever the direction.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register holds all ones, the output latch holds 0x00, no pad driver is enabled and the read data output is 0x00.
- R2: Register addresses are 0 = pin levels, 1 = output latch, 2 = direction; address 3 is reserved, so writes to it change nothing and reads of it return 0x00.
- R3: A write to address 0 or to address 1 stores the write data into the same output latch.
- R4: A read of address 1 returns the stored latch value, never the pad levels.
- R5: A read of address 0 returns the pad input levels as seen through a two-flop synchronizer.
- R6: With no peripheral select and no force-input on a bit, direction bit 1 turns the driver off and direction bit 0 turns it on and drives the latch bit; writing 0xCF leaves only bits 5 and 4 driven.
- R7: When a bit's peripheral select is 1, the pad drives that bit of the peripheral data output instead of the latch.
- R8: When a bit's peripheral select is 1, its driver enable follows the peripheral output enable; with select 0 the peripheral output enable has no effect.
- R9: A force-input bit of 1 turns that bit's driver off regardless of select, peripheral enable or direction.
- R10: A read of address 2 returns the stored direction value even while selects or force-input bits override the pads.
- R11: The peripheral data input equals the pad input delayed by two clock edges, for every bit and every direction.
- R12: Read data is registered: it changes on the edge where the read strobe is sampled, holds otherwise, and a read in the same cycle as a write to that register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| per_sel | input | 8 | Per-bit peripheral select |
| per_oe | input | 8 | Per-bit peripheral output enable |
| per_out | input | 8 | Per-bit peripheral data output |
| force_in | input | 8 | Per-bit force-to-input |
| per_in | output | 8 | Synchronized pin level to peripherals |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad driver enable |

## Verification
A register write and a register read can fall in the same cycle, and the bench provokes this by raising both strobes on the latch address in one cycle and expecting the old latch value, then the new one on the following read. Peripheral overrides and direction reads also coincide: with selects and force-input bits active the bench compares the pad enables against the combined rule while reading the direction register and expecting the untouched stored value. Every read's expected value is queued by the driver and compared by a monitor at the edge the read data is registered.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_RSVD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q
);
  reg_sel_e         sel;
  logic             lat_we;
  logic             dir_we;
  logic [WIDTH-1:0] rd_mux;

  assign sel    = reg_sel_e'(addr);
  assign lat_we = wr_en && (sel == REG_PINS || sel == REG_LATCH);
  assign dir_we = wr_en && (sel == REG_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_we) lat_q <= wr_data;
      if (dir_we) dir_q <= wr_data;
    end
  end

  always_comb begin
    unique case (sel)
      REG_PINS:  rd_mux = pin_sync;
      REG_LATCH: rd_mux = lat_q;
      REG_DIR:   rd_mux = dir_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] per_sel,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] force_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic drive_req;
      assign pad_out[b] = per_sel[b] ? per_out[b] : lat_q[b];
      assign drive_req  = per_sel[b] ? per_oe[b]  : ~dir_q[b];
      assign pad_oe[b]  = drive_req & ~force_in[b];
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  per_sel,
  input  logic [WIDTH-1:0]  per_oe,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  force_in,
  output logic [WIDTH-1:0]  per_in,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .lat_q    (lat_q),
    .dir_q    (dir_q)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .lat_q    (lat_q),
    .dir_q    (dir_q),
    .per_sel  (per_sel),
    .per_oe   (per_oe),
    .per_out  (per_out),
    .force_in (force_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign per_in = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [WIDTH-1:0]  wr_data,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data,
  input logic [WIDTH-1:0]  per_sel,
  input logic [WIDTH-1:0]  per_out,
  input logic [WIDTH-1:0]  force_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  lat_q,
  input logic [WIDTH-1:0]  dir_q
);
  // R1: direction register comes out of reset as all inputs
  assert_reset_dir_R1: assert property (@(posedge clk)
    $fell(rst) |-> (dir_q == '1 && lat_q == '0));

  // R3: pin or latch address writes reach the latch
  assert_latch_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == REG_PINS || addr == REG_LATCH)) |=> lat_q == $past(wr_data));

  // R4: latch reads return the stored latch
  assert_latch_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_LATCH) |=> rd_data == $past(lat_q));

  // R7: selected bits drive the peripheral data
  assert_per_data_R7: assert property (@(posedge clk) disable iff (rst)
    ((pad_out ^ per_out) & per_sel) == '0);

  // R9: forced bits never drive
  assert_force_in_R9: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & force_in) == '0);

  // R10: direction register only changes through its own write
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_DIR) |=> $stable(dir_q));

  // R12: read data holds while no read strobe is sampled
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .per_sel  (per_sel),
  .per_out  (per_out),
  .force_in (force_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .lat_q    (lat_q),
  .dir_q    (dir_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic [W-1:0] per_sel = '0;
  logic [W-1:0] per_oe = '0;
  logic [W-1:0] per_out = '0;
  logic [W-1:0] force_in = '0;
  logic [W-1:0] per_in;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .per_sel(per_sel), .per_oe(per_oe),
    .per_out(per_out), .force_in(force_in), .per_in(per_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_rd(input logic [1:0] a, input logic [W-1:0] d,
                       input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // monitor: compare each registered read result
  always @(posedge clk) begin
    if (rd_en && !rst) begin
      #2;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd(2'd2, 8'hFF, "R1 dir reset value");
    rd(2'd1, 8'h00, "R1 latch reset value");

    // R6: direction 0xCF drives bits 5:4 only
    wr(2'd2, 8'hCF);
    wr(2'd1, 8'hA5);
    @(negedge clk);
    check("R6 pad_oe with dir CF", pad_oe, 8'h30);
    check("R6 pad_out follows latch", pad_out, 8'hA5);

    // R3: pin address write also hits the latch
    wr(2'd0, 8'h3C);
    rd(2'd1, 8'h3C, "R3 pin-address write stored in latch");

    // R4/R5: latch read vs pin read
    @(negedge clk); pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(2'd1, 8'h3C, "R4 latch read ignores pads");
    rd(2'd0, 8'hC3, "R5 pin read returns pad levels");

    // R11: two-edge latency on per_in, output bits included
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk);
    check("R11 per_in after one edge", per_in, 8'hC3);
    @(negedge clk);
    check("R11 per_in after two edges", per_in, 8'h5A);

    // R7/R8: peripheral takeover of low nibble
    per_sel = 8'h0F; per_out = 8'h06; per_oe = 8'h05;
    #1;
    check("R7 pad_out mixes peripheral data", pad_out, 8'h36);
    check("R8 pad_oe from peripheral enable", pad_oe, 8'h35);
    per_oe = 8'hF5;
    #1;
    check("R8 unselected peripheral enable ignored", pad_oe, 8'h35);

    // R9/R10: force-input plus direction readback under override
    force_in = 8'h31;
    #1;
    check("R9 force-input clears drivers", pad_oe, 8'h04);
    rd(2'd2, 8'hCF, "R10 dir readback under override");
    @(negedge clk);
    per_sel = '0; per_oe = '0; per_out = '0; force_in = '0;

    // R12: same-cycle write and read of latch
    wr_rd(2'd1, 8'h99, 8'h3C, "R12 read during write returns old");
    rd(2'd1, 8'h99, "R12 next read returns new");
    repeat (3) @(negedge clk);
    check("R12 rd_data holds when idle", rd_data, 8'h99);

    // R2: reserved address
    wr(2'd3, 8'h00);
    rd(2'd2, 8'hCF, "R2 reserved write leaves dir");
    rd(2'd1, 8'h99, "R2 reserved write leaves latch");
    rd(2'd3, 8'h00, "R2 reserved read returns zero");
    @(negedge clk);
    check("R6 pad_out after overrides removed", pad_out, 8'h99);
    check("R6 pad_oe after overrides removed", pad_oe, 8'h30);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule